// File: doc/BRIEF.md
# Flow-Controlled Link Word Sender

This block is the sending end of a parallel link. It puts data or control words on a bus and marks each one with an active-low write strobe. An active-low control flag tells a control word apart from a data word. The receiving end can report that it is nearly full through an active-low full flag. After that flag is seen low, the sender may still issue a fixed number of further words, and then it waits until the flag returns high. The sender can also reset the link. It lowers an active-low link reset, waits for the receiver's active-low link-down indicator to fall and then rise, releases the reset, and keeps the bus quiet for a set number of cycles.

Work arrives on a command port with a valid/ready handshake. A command can ask for one data word, one control word, a burst of pattern words, or a link reset. The back-pressure rules are:
- `cmd_ready` is high only while the block is idle.
- A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- Operands (word, count, seed, step) are sampled at that edge.
- A one-cycle `cmd_done` pulse closes each command.

Burst words come from a pattern source. It either rotates a single one bit left, or adds a fixed step to the previous value. It starts from a seed.

Top module: `link_sender`

## Requirements
- R1: A word is transferred at each rising clock edge where `tx_wen_n` is low. `tx_ctrl_n` is low with it for a control command (op 1) and high for a data command (op 0) and for burst words.
- R2: Once `link_full_n` is sampled low, at most EXTRA_WORDS (default 2) further words are issued. Issuing resumes after `link_full_n` is sampled high again.
- R3: A reset command (op 3) drives `link_rst_n` low. It stays low until `link_down_n` has been sampled low and then high. No word is written while it is low.
- R4: After `link_rst_n` rises, `tx_wen_n` stays high for at least IDLE_CYCLES (default 4) cycles.
- R5: The bus width DATA_W is an elaboration parameter limited to 8, 16 or 32, with 32 as the default. Pattern arithmetic and rotation wrap at that width.
- R6: A burst (op 2) starts at `cfg_seed`. With `cfg_step` = 0, each next word is the previous one rotated left by one bit, with the top bit wrapping to bit 0.
- R7: With a nonzero `cfg_step`, each next burst word is the previous word plus the step, modulo 2^DATA_W.
- R8: A burst of count N writes exactly N consecutive pattern words, with no word skipped or repeated across stalls. A count of 0 writes nothing and completes at once.
- R9: `cmd_ready` is high only when idle. `cmd_done` is a one-cycle pulse. It comes in the same cycle as the strobe of the last word, or when the reset handshake and quiet period have ended.
- R10: While `tx_wen_n` is high, `tx_data` holds its value. No word is written in a cycle following an idle cycle.
- R11: `test_mode_n` follows `cfg_test_n` with one cycle of delay.
- R12: During and right after reset:
  - `tx_wen_n`, `tx_ctrl_n` and `link_rst_n` are high.
  - `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 data, 1 control, 2 burst, 3 link reset |
| cmd_word | input | DATA_W | Word for single-word commands |
| cmd_count | input | COUNT_W | Burst length |
| cmd_done | output | 1 | Command completed pulse |
| cfg_seed | input | DATA_W | First burst word |
| cfg_step | input | DATA_W | Burst increment, 0 selects rotating one |
| cfg_test_n | input | 1 | Level for test output |
| link_full_n | input | 1 | Receiver nearly full, active low |
| link_down_n | input | 1 | Receiver link down, active low |
| tx_data | output | DATA_W | Word bus |
| tx_wen_n | output | 1 | Write strobe, active low |
| tx_ctrl_n | output | 1 | Control word flag, active low |
| link_rst_n | output | 1 | Link reset, active low |
| test_mode_n | output | 1 | Test level output |

## Verification
A table of commands drives the main sending function with several input patterns:
- A lone data word and a lone control word, which exercise the control flag.
- A rotating-one burst from bit 0, and one seeded near the top bit so that the rotation must wrap to bit 0.
- An adding burst seeded close to all ones, so that the sum must overflow.
- A zero-length burst.

A long burst is stalled by the full flag partway through. This shows the exact extra-word allowance, that the bus holds its value while stalled, and that the pattern resumes without a gap or a repeat. A reset command is run with a slow link-down response. This separates the two handshake phases and measures the quiet gap before the next write.

// File: rtl/link_sender_pkg.sv
package link_sender_pkg;
  typedef enum logic [1:0] {
    OP_DATA  = 2'd0,
    OP_CTRL  = 2'd1,
    OP_BURST = 2'd2,
    OP_RESET = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RESET
  } st_e;
endpackage

// File: rtl/link_sender_pattern.sv
module link_sender_pattern #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] step,
  input  logic              advance,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] step_q;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    if (step_q == '0) nxt = {value[DATA_W-2:0], value[DATA_W-1]};
    else              nxt = value + step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      step_q <= '0;
    end else if (load) begin
      value  <= seed;
      step_q <= step;
    end else if (advance) begin
      value  <= nxt;
    end
  end
endmodule

// File: rtl/link_sender_credit.sv
module link_sender_credit #(
  parameter int EXTRA_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_full_n,
  input  logic issue,
  output logic can_send
);
  localparam int CW = $clog2(EXTRA_WORDS + 2);
  logic [CW-1:0] cred;

  assign can_send = link_full_n || (cred != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cred <= CW'(EXTRA_WORDS);
    else if (link_full_n)             cred <= CW'(EXTRA_WORDS);
    else if (issue && cred != '0)     cred <= cred - 1'b1;
  end
endmodule

// File: rtl/link_sender_rstseq.sv
module link_sender_rstseq #(
  parameter int IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic link_down_n,
  output logic link_rst_n,
  output logic done
);
  localparam int HW = $clog2(IDLE_CYCLES + 1);
  typedef enum logic [1:0] {R_OFF, R_WAIT_DN, R_WAIT_UP, R_QUIET} rs_e;
  rs_e           rs;
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs         <= R_OFF;
      link_rst_n <= 1'b1;
      done       <= 1'b0;
      hold       <= '0;
    end else begin
      done <= 1'b0;
      case (rs)
        R_OFF: if (start) begin
          link_rst_n <= 1'b0;
          rs         <= R_WAIT_DN;
        end
        R_WAIT_DN: if (!link_down_n) rs <= R_WAIT_UP;
        R_WAIT_UP: if (link_down_n) begin
          link_rst_n <= 1'b1;
          hold       <= HW'(IDLE_CYCLES);
          rs         <= R_QUIET;
        end
        R_QUIET: begin
          if (hold == HW'(1)) begin
            done <= 1'b1;
            rs   <= R_OFF;
          end else begin
            hold <= hold - 1'b1;
          end
        end
        default: rs <= R_OFF;
      endcase
    end
  end
endmodule

// File: rtl/link_sender.sv
module link_sender
  import link_sender_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int EXTRA_WORDS = 2,
  parameter int IDLE_CYCLES = 4,
  parameter int COUNT_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [DATA_W-1:0]  cmd_word,
  input  logic [COUNT_W-1:0] cmd_count,
  output logic               cmd_done,
  input  logic [DATA_W-1:0]  cfg_seed,
  input  logic [DATA_W-1:0]  cfg_step,
  input  logic               cfg_test_n,
  input  logic               link_full_n,
  input  logic               link_down_n,
  output logic [DATA_W-1:0]  tx_data,
  output logic               tx_wen_n,
  output logic               tx_ctrl_n,
  output logic               link_rst_n,
  output logic               test_mode_n
);
  generate
    if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32)) begin : g_bad_width
      $error("link_sender: DATA_W must be 8, 16 or 32");
    end
  endgenerate

  st_e                state;
  logic [COUNT_W-1:0] remain;
  logic [DATA_W-1:0]  word_q;
  logic               is_ctrl_q;
  logic               from_pat_q;
  logic               send_done;
  logic               seq_done;
  logic               can_send;
  logic               accept;
  logic               issue;
  logic [DATA_W-1:0]  pat_value;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign issue     = (state == ST_SEND) && can_send;
  assign cmd_done  = send_done || seq_done;

  link_sender_pattern #(.DATA_W(DATA_W)) u_pattern (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && cmd_op == OP_BURST),
    .seed    (cfg_seed),
    .step    (cfg_step),
    .advance (issue && from_pat_q),
    .value   (pat_value)
  );

  link_sender_credit #(.EXTRA_WORDS(EXTRA_WORDS)) u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_full_n (link_full_n),
    .issue       (issue),
    .can_send    (can_send)
  );

  link_sender_rstseq #(.IDLE_CYCLES(IDLE_CYCLES)) u_rstseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept && cmd_op == OP_RESET),
    .link_down_n (link_down_n),
    .link_rst_n  (link_rst_n),
    .done        (seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_mode_n <= cfg_test_n;
    else        test_mode_n <= cfg_test_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      remain     <= '0;
      word_q     <= '0;
      is_ctrl_q  <= 1'b0;
      from_pat_q <= 1'b0;
      send_done  <= 1'b0;
      tx_data    <= '0;
      tx_wen_n   <= 1'b1;
      tx_ctrl_n  <= 1'b1;
    end else begin
      send_done <= 1'b0;
      tx_wen_n  <= 1'b1;
      tx_ctrl_n <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            case (cmd_op)
              OP_DATA, OP_CTRL: begin
                word_q     <= cmd_word;
                is_ctrl_q  <= (cmd_op == OP_CTRL);
                from_pat_q <= 1'b0;
                remain     <= COUNT_W'(1);
                state      <= ST_SEND;
              end
              OP_BURST: begin
                is_ctrl_q  <= 1'b0;
                from_pat_q <= 1'b1;
                remain     <= cmd_count;
                if (cmd_count == '0) send_done <= 1'b1;
                else                 state     <= ST_SEND;
              end
              default: state <= ST_RESET;
            endcase
          end
        end
        ST_SEND: begin
          if (can_send) begin
            tx_wen_n  <= 1'b0;
            tx_ctrl_n <= !is_ctrl_q;
            tx_data   <= from_pat_q ? pat_value : word_q;
            remain    <= remain - 1'b1;
            if (remain == COUNT_W'(1)) begin
              send_done <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_RESET: if (seq_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_sender_chk.sv
module link_sender_chk #(
  parameter int DATA_W      = 32,
  parameter int EXTRA_WORDS = 2,
  parameter int IDLE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_done,
  input logic              cfg_test_n,
  input logic              link_full_n,
  input logic              link_down_n,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_wen_n,
  input logic              link_rst_n,
  input logic              test_mode_n
);
  logic       full_q;
  logic [7:0] under_full;
  logic [7:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b1;
      under_full <= '0;
      since_rel  <= 8'(IDLE_CYCLES);
    end else begin
      full_q <= link_full_n;
      if (link_full_n)                                under_full <= '0;
      else if (!tx_wen_n && !full_q && under_full != 8'hFF) under_full <= under_full + 1'b1;
      if (!link_rst_n)                                since_rel <= '0;
      else if (since_rel < 8'(IDLE_CYCLES))           since_rel <= since_rel + 1'b1;
    end
  end

  p_extra_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    under_full <= 8'(EXTRA_WORDS));
  p_quiet_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !link_rst_n |-> tx_wen_n);
  p_release_after_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_rst_n) |-> $past(link_down_n));
  p_idle_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rel < 8'(IDLE_CYCLES)) |-> tx_wen_n);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wen_n |-> $stable(tx_data));
  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && $past(cmd_ready)) |-> tx_wen_n);
  p_test_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode_n == $past(cfg_test_n));
endmodule

bind link_sender link_sender_chk #(
  .DATA_W(DATA_W), .EXTRA_WORDS(EXTRA_WORDS), .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
  .cfg_test_n(cfg_test_n), .link_full_n(link_full_n), .link_down_n(link_down_n),
  .tx_data(tx_data), .tx_wen_n(tx_wen_n), .link_rst_n(link_rst_n),
  .test_mode_n(test_mode_n)
);

// File: tb/link_sender_tb.sv
`timescale 1ns/1ps
module link_sender_tb;
  localparam int DW = 32;
  localparam int EXTRA = 2;
  localparam int IDLE = 4;
  localparam int CW = 16;

  typedef struct packed {
    logic [1:0]    op;
    logic [DW-1:0] word;
    logic [CW-1:0] cnt;
    logic [DW-1:0] seed;
    logic [DW-1:0] step;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'hA5A5_0001, 16'd0, 32'h0,          32'h0},
    '{2'd1, 32'h0000_00C3, 16'd0, 32'h0,          32'h0},
    '{2'd2, 32'h0,         16'd6, 32'h0000_0001,  32'h0},
    '{2'd2, 32'h0,         16'd4, 32'h4000_0000,  32'h0},
    '{2'd2, 32'h0,         16'd5, 32'hFFFF_FFFE,  32'h3},
    '{2'd2, 32'h0,         16'd0, 32'h0000_0001,  32'h1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, cmd_done;
  logic [1:0] cmd_op;
  logic [DW-1:0] cmd_word, cfg_seed, cfg_step, tx_data;
  logic [CW-1:0] cmd_count;
  logic cfg_test_n, link_full_n, link_down_n;
  logic tx_wen_n, tx_ctrl_n, link_rst_n, test_mode_n;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  logic done_wen_low = 1'b0;
  logic [DW:0] cap[$];

  always #2.5 clk = ~clk;

  link_sender #(.DATA_W(DW), .EXTRA_WORDS(EXTRA), .IDLE_CYCLES(IDLE), .COUNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_count(cmd_count), .cmd_done(cmd_done),
    .cfg_seed(cfg_seed), .cfg_step(cfg_step), .cfg_test_n(cfg_test_n),
    .link_full_n(link_full_n), .link_down_n(link_down_n), .tx_data(tx_data),
    .tx_wen_n(tx_wen_n), .tx_ctrl_n(tx_ctrl_n), .link_rst_n(link_rst_n),
    .test_mode_n(test_mode_n)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!tx_wen_n) cap.push_back({tx_ctrl_n, tx_data});
      if (cmd_done) begin
        done_cnt++;
        done_wen_low = !tx_wen_n;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [DW-1:0] w, input logic [CW-1:0] n);
    @(negedge clk);
    cmd_op = op; cmd_word = w; cmd_count = n; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int k = 0;
    while (done_cnt <= prev && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(done_cnt > prev, "R9 done", 64'(done_cnt), 64'(prev + 1));
  endtask

  function automatic logic [DW-1:0] next_pat(input logic [DW-1:0] cur, input logic [DW-1:0] st);
    return (st == '0) ? {cur[DW-2:0], cur[DW-1]} : cur + st;
  endfunction

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_word = '0; cmd_count = '0;
    cfg_seed = '0; cfg_step = '0; cfg_test_n = 1'b1; link_full_n = 1'b1; link_down_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(tx_wen_n == 1'b1, "R12 wen", 64'(tx_wen_n), 64'd1);
    check(tx_ctrl_n == 1'b1, "R12 ctrl", 64'(tx_ctrl_n), 64'd1);
    check(link_rst_n == 1'b1, "R12 link reset", 64'(link_rst_n), 64'd1);
    check(cmd_ready == 1'b1, "R12 ready", 64'(cmd_ready), 64'd1);
    check($bits(tx_data) == 32, "R5 width", 64'($bits(tx_data)), 64'd32);

    // R11 test level
    cfg_test_n = 1'b0;
    @(negedge clk);
    check(test_mode_n == 1'b0, "R11 low", 64'(test_mode_n), 64'd0);
    cfg_test_n = 1'b1;
    @(negedge clk);
    check(test_mode_n == 1'b1, "R11 high", 64'(test_mode_n), 64'd1);

    // vector table: R1 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VEC[v];
      automatic int prev = done_cnt;
      automatic logic [DW:0] exp_q[$];
      automatic logic [DW-1:0] cur;
      cfg_seed = t.seed;
      cfg_step = t.step;
      cap.delete();
      send_cmd(t.op, t.word, t.cnt);
      wait_done(prev);
      if (t.cnt != 0 || t.op != 2'd2)
        check(done_wen_low, "R9 done with last word", 64'(done_wen_low), 64'd1);
      repeat (2) @(negedge clk);
      if (t.op == 2'd0) exp_q.push_back({1'b1, t.word});
      else if (t.op == 2'd1) exp_q.push_back({1'b0, t.word});
      else begin
        cur = t.seed;
        for (int i = 0; i < int'(t.cnt); i++) begin
          exp_q.push_back({1'b1, cur});
          cur = next_pat(cur, t.step);
        end
      end
      check(cap.size() == exp_q.size(), "R8 word count", 64'(cap.size()), 64'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < cap.size(); i++)
        check(cap[i] == exp_q[i], (t.op != 2'd2) ? "R1 word" : (t.step == 0 ? "R6 rotate" : "R7 add"),
              64'(cap[i]), 64'(exp_q[i]));
    end

    // R2 full stall in a long burst
    begin
      automatic int prev = done_cnt;
      automatic int n = 0;
      automatic logic [DW-1:0] u1;
      automatic logic [DW-1:0] cur = 32'h5;
      cfg_seed = 32'h5;
      cfg_step = 32'h7;
      cap.delete();
      send_cmd(2'd2, '0, 16'd20);
      repeat (3) @(negedge clk);
      link_full_n = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (!tx_wen_n) n++;
      end
      check(n == EXTRA, "R2 extra words", 64'(n), 64'(EXTRA));
      u1 = tx_data;
      @(negedge clk);
      check(tx_wen_n && tx_data == u1, "R10 hold while stalled", 64'(tx_data), 64'(u1));
      link_full_n = 1'b1;
      wait_done(prev);
      repeat (2) @(negedge clk);
      check(cap.size() == 20, "R8 stall count", 64'(cap.size()), 64'd20);
      for (int i = 0; i < 20 && i < cap.size(); i++) begin
        check(cap[i] == {1'b1, cur}, "R8 resume order", 64'(cap[i]), 64'({1'b1, cur}));
        cur = cur + 32'h7;
      end
    end

    // R3 R4 link reset handshake
    begin
      automatic int prev = done_cnt;
      automatic int k = 0;
      send_cmd(2'd3, '0, '0);
      check(link_rst_n == 1'b0, "R3 asserted", 64'(link_rst_n), 64'd0);
      repeat (5) @(negedge clk);
      check(link_rst_n == 1'b0, "R3 waits down", 64'(link_rst_n), 64'd0);
      link_down_n = 1'b0;
      repeat (3) @(negedge clk);
      check(link_rst_n == 1'b0, "R3 waits up", 64'(link_rst_n), 64'd0);
      link_down_n = 1'b1;
      @(negedge clk);
      check(link_rst_n == 1'b1, "R3 released", 64'(link_rst_n), 64'd1);
      fork
        send_cmd(2'd0, 32'h1234, '0);
      join_none
      while (tx_wen_n && k < 100) begin
        @(negedge clk);
        k++;
      end
      check(k >= IDLE, "R4 quiet gap", 64'(k), 64'(IDLE));
      @(negedge clk);
      check(done_cnt == prev + 2, "R9 reset and data done", 64'(done_cnt), 64'(prev + 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule